// File: doc/BRIEF.md
# Packed 4:2:2 YUV Layer Unpacker with RGB Conversion

This block sits between a framebuffer word fetcher and a layer compositor. It takes 32-bit words holding packed 4:2:2 luma/chroma data. Each word holds two luma samples that share one blue-difference and one red-difference sample. The block splits each word into two pixels and converts each pixel to 8-bit R, G and B with a programmable matrix. It then hands the pixels downstream on a valid/ready stream that carries an end-of-line flag. When the layer's colour mode is off, each word leaves unchanged as a single RGB pixel.

A 2-bit sequence code selects the byte arrangement. The code is named by reading its letters from the most significant byte down to byte 0, which is the byte at the lowest address. A memory layout written left to right therefore uses the code whose name is that layout reversed. For example, memory order Y-U-Y-V is selected by code 3. The twelve coefficients are written one index at a time through a small write port before the layer runs. The line length is programmed in bits.

The control is a three-state machine. FETCH waits for a word and raises `in_ready`. The transition FETCH->LEAD fires on an accepted word and latches the word, the code and the mode. LEAD presents the first pixel, or the bypassed word. In colour mode, the transition LEAD->TRAIL fires on output acceptance; in bypass, the transition LEAD->FETCH fires instead. TRAIL presents the second pixel, and TRAIL->FETCH fires on output acceptance.

Top module: `pk422_rgb_unpacker`

## Requirements
- R1: After reset `pix_valid` and `pix_eol` are 0 and `in_ready` is 1.
- R2: Byte b0 is `in_word[7:0]` and b3 is `in_word[31:24]`. The fields taken per `seq_code` are: 0: V=b0, Y0=b1, U=b2, Y1=b3. 1: U=b0, Y0=b1, V=b2, Y1=b3. 2: Y0=b0, V=b1, Y1=b2, U=b3. 3: Y0=b0, U=b1, Y1=b2, V=b3.
- R3: For colour channel c (0=R, 1=G, 2=B), the result is floor((k[3c]·Y + k[3c+1]·U + k[3c+2]·V) / 1024) + k[9+c]. Each k is a signed 16-bit coefficient, and U and V are used unbiased in 0..255. `pix_data` is {8'h00, R, G, B} with R in bits 23:16.
- R4: Each channel result is clamped to 0 when negative and to 255 when above 255.
- R5: With `yuv_mode` 0, each word yields exactly one pixel and `pix_data` equals the word bit for bit.
- R6: With `yuv_mode` 1, each word yields two pixels in order, the first using Y0 and the second Y1, and both use the word's U and V.
- R7: `pix_eol` marks the last pixel of a line. A line holds `line_bits`/16 pixels in colour mode and `line_bits`/32 in bypass, and counting restarts after the marked pixel.
- R8: While `pix_valid` is 1 and `pix_ready` is 0, the pixel and its end-of-line flag are held and `in_ready` stays 0. Every pixel is delivered exactly once.
- R9: A write with `cfg_we` 1 stores `cfg_data` into coefficient `cfg_idx` (0..11) from the next cycle on. Writes to indices 12..15 change nothing.
- R10: `seq_code` and `yuv_mode` are captured when a word is accepted. Later changes do not affect that word's pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high with valid |
| in_word | input | 32 | Packed word from the fetcher |
| seq_code | input | 2 | Byte sequence code |
| yuv_mode | input | 1 | 1 = convert, 0 = pass words through |
| line_bits | input | 16 | Line length in bits |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_idx | input | 4 | Coefficient index |
| cfg_data | input | 16 | Signed coefficient value |
| pix_valid | output | 1 | Output pixel valid |
| pix_ready | input | 1 | Downstream accepts pixel |
| pix_data | output | 32 | Pixel: {0,R,G,B} or the unchanged word |
| pix_eol | output | 1 | Last pixel of the line |

## Verification
Two of this block's functions can land in the same cycle. The end-of-line marker can fall on a pixel that downstream back-pressure is holding. The bench provokes this by stalling `pix_ready` on the final pixel of a line while a further word waits at the input. For several cycles it checks that the pixel value, the marker and the refused `in_ready` all hold. After release, it checks that the next line starts counting from zero.

// File: rtl/pk422_pkg.sv
package pk422_pkg;

    typedef enum logic [1:0] {
        ST_FETCH = 2'd0,
        ST_LEAD  = 2'd1,
        ST_TRAIL = 2'd2
    } unpack_state_e;

    typedef struct packed {
        logic [7:0] y0;
        logic [7:0] y1;
        logic [7:0] cb;
        logic [7:0] cr;
    } yuv_pair_t;

    localparam int NUM_CHAN = 3;
    localparam int TAPS_PER_CHAN = 3;
    localparam int NUM_COEF = NUM_CHAN * TAPS_PER_CHAN + NUM_CHAN;

endpackage

// File: rtl/pk422_lane_sel.sv
module pk422_lane_sel
    import pk422_pkg::*;
(
    input  logic [31:0] word,
    input  logic [1:0]  code,
    output yuv_pair_t   pair
);
    logic [7:0] b0, b1, b2, b3;

    assign b0 = word[7:0];
    assign b1 = word[15:8];
    assign b2 = word[23:16];
    assign b3 = word[31:24];

    always_comb begin
        unique case (code)
            2'd0: pair = '{y0: b1, y1: b3, cb: b2, cr: b0};
            2'd1: pair = '{y0: b1, y1: b3, cb: b0, cr: b2};
            2'd2: pair = '{y0: b0, y1: b2, cb: b3, cr: b1};
            default: pair = '{y0: b0, y1: b2, cb: b1, cr: b3};
        endcase
    end
endmodule

// File: rtl/pk422_coef_bank.sv
module pk422_coef_bank
    import pk422_pkg::*;
#(
    parameter int COEF_W = 16,
    parameter int IDX_W  = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               cfg_we,
    input  logic [IDX_W-1:0]                   cfg_idx,
    input  logic [COEF_W-1:0]                  cfg_data,
    output logic [NUM_COEF-1:0][COEF_W-1:0]    coefs
);
    for (genvar k = 0; k < NUM_COEF; k++) begin : g_coef
        always_ff @(posedge clk) begin
            if (!rst_n)
                coefs[k] <= '0;
            else if (cfg_we && cfg_idx == IDX_W'(k))
                coefs[k] <= cfg_data;
        end
    end

    // R9
    coef_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_idx >= IDX_W'(NUM_COEF)) |=> $stable(coefs));
endmodule

// File: rtl/pk422_csc.sv
module pk422_csc #(
    parameter int COEF_W = 16,
    parameter int FRAC_W = 10
) (
    input  logic [7:0]               luma,
    input  logic [7:0]               cb,
    input  logic [7:0]               cr,
    input  logic signed [COEF_W-1:0] k_y,
    input  logic signed [COEF_W-1:0] k_b,
    input  logic signed [COEF_W-1:0] k_r,
    input  logic signed [COEF_W-1:0] k_off,
    output logic [7:0]               chan
);
    localparam int ACC_W = COEF_W + FRAC_W + 12;

    logic signed [ACC_W-1:0] p_y, p_b, p_r, p_off, acc, scaled;

    always_comb begin
        p_y    = ACC_W'(k_y) * ACC_W'($signed({1'b0, luma}));
        p_b    = ACC_W'(k_b) * ACC_W'($signed({1'b0, cb}));
        p_r    = ACC_W'(k_r) * ACC_W'($signed({1'b0, cr}));
        p_off  = ACC_W'(k_off) <<< FRAC_W;
        acc    = p_y + p_b + p_r + p_off;
        scaled = acc >>> FRAC_W;
        if (scaled < 0)
            chan = 8'h00;
        else if (scaled > 255)
            chan = 8'hFF;
        else
            chan = scaled[7:0];
    end
endmodule

// File: rtl/pk422_rgb_unpacker.sv
module pk422_rgb_unpacker
    import pk422_pkg::*;
#(
    parameter int COEF_W = 16,
    parameter int FRAC_W = 10,
    parameter int LB_W   = 16,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [31:0]       in_word,
    input  logic [1:0]        seq_code,
    input  logic              yuv_mode,
    input  logic [LB_W-1:0]   line_bits,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [COEF_W-1:0] cfg_data,
    output logic              pix_valid,
    input  logic              pix_ready,
    output logic [31:0]       pix_data,
    output logic              pix_eol
);
    localparam int YUV_SHIFT = 4;
    localparam int RGB_SHIFT = 5;

    unpack_state_e state, state_nx;
    logic [31:0]     word_q;
    logic [1:0]      code_q;
    logic            mode_q;
    logic [LB_W-1:0] cnt_q, ppl;
    logic            accept, emit;
    yuv_pair_t       pair;
    logic [7:0]      luma;
    logic [NUM_COEF-1:0][COEF_W-1:0] coefs;
    logic [NUM_CHAN-1:0][7:0]        rgb;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_FETCH;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_FETCH: if (in_valid) state_nx = ST_LEAD;
            ST_LEAD:  if (pix_ready) state_nx = mode_q ? ST_TRAIL : ST_FETCH;
            ST_TRAIL: if (pix_ready) state_nx = ST_FETCH;
            default:  state_nx = ST_FETCH;
        endcase
    end

    // outputs of the machine
    always_comb begin
        in_ready  = 1'b0;
        pix_valid = 1'b0;
        unique case (state)
            ST_FETCH: in_ready  = 1'b1;
            ST_LEAD:  pix_valid = 1'b1;
            ST_TRAIL: pix_valid = 1'b1;
            default: ;
        endcase
    end

    assign accept = in_valid & in_ready;
    assign emit   = pix_valid & pix_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            code_q <= '0;
            mode_q <= 1'b0;
        end else if (accept) begin
            word_q <= in_word;
            code_q <= seq_code;
            mode_q <= yuv_mode;
        end
    end

    // line position
    assign ppl = mode_q ? (line_bits >> YUV_SHIFT) : (line_bits >> RGB_SHIFT);

    always_comb begin
        pix_eol = 1'b0;
        if (pix_valid)
            pix_eol = ({1'b0, cnt_q} + 1'b1) >= {1'b0, ppl};
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (emit)    cnt_q <= pix_eol ? '0 : cnt_q + 1'b1;
    end

    // datapath
    pk422_lane_sel u_lanes (
        .word (word_q),
        .code (code_q),
        .pair (pair)
    );

    pk422_coef_bank #(.COEF_W(COEF_W), .IDX_W(IDX_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_idx  (cfg_idx),
        .cfg_data (cfg_data),
        .coefs    (coefs)
    );

    assign luma = (state == ST_TRAIL) ? pair.y1 : pair.y0;

    for (genvar ch = 0; ch < NUM_CHAN; ch++) begin : g_chan
        pk422_csc #(.COEF_W(COEF_W), .FRAC_W(FRAC_W)) u_csc (
            .luma  (luma),
            .cb    (pair.cb),
            .cr    (pair.cr),
            .k_y   ($signed(coefs[ch*TAPS_PER_CHAN + 0])),
            .k_b   ($signed(coefs[ch*TAPS_PER_CHAN + 1])),
            .k_r   ($signed(coefs[ch*TAPS_PER_CHAN + 2])),
            .k_off ($signed(coefs[NUM_CHAN*TAPS_PER_CHAN + ch])),
            .chan  (rgb[NUM_CHAN-1-ch])
        );
    end

    assign pix_data = mode_q ? {8'h00, rgb} : word_q;

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !pix_ready && !cfg_we) |=>
            (pix_valid && $stable(pix_data) && $stable(pix_eol)));

    // R8
    busy_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (pix_valid && !in_ready));

    // R7
    eol_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_eol |-> pix_valid);

    // R6
    pair_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LEAD && mode_q && pix_ready) |=> (pix_valid && !in_ready));
endmodule

// File: tb/pk422_rgb_unpacker_tb_top.sv
module pk422_rgb_unpacker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_word = '0;
    logic [1:0]  seq_code = '0;
    logic        yuv_mode = 1'b1;
    logic [15:0] line_bits = 16'd64;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_idx = '0;
    logic [15:0] cfg_data = '0;
    logic        pix_valid;
    logic        pix_ready = 1'b0;
    logic [31:0] pix_data;
    logic        pix_eol;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int cf [12];
    int line_pos = 0;

    always #4 clk = ~clk;

    pk422_rgb_unpacker dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_word(in_word), .seq_code(seq_code), .yuv_mode(yuv_mode),
        .line_bits(line_bits), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_data(cfg_data), .pix_valid(pix_valid), .pix_ready(pix_ready),
        .pix_data(pix_data), .pix_eol(pix_eol)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int chan_model(int y, int u, int v, int c);
        int acc = cf[3*c]*y + cf[3*c+1]*u + cf[3*c+2]*v;
        int r = (acc >>> 10) + cf[9+c];
        if (r < 0) r = 0;
        if (r > 255) r = 255;
        return r;
    endfunction

    // field extraction per R2, from byte lanes
    function automatic logic [31:0] pix_model(logic [31:0] w, logic [1:0] code, bit second);
        int b0 = int'(w[7:0]), b1 = int'(w[15:8]), b2 = int'(w[23:16]), b3 = int'(w[31:24]);
        int y0, y1, u, v, y;
        case (code)
            2'd0: begin v = b0; y0 = b1; u = b2; y1 = b3; end
            2'd1: begin u = b0; y0 = b1; v = b2; y1 = b3; end
            2'd2: begin y0 = b0; v = b1; y1 = b2; u = b3; end
            default: begin y0 = b0; u = b1; y1 = b2; v = b3; end
        endcase
        y = second ? y1 : y0;
        return {8'h00, 8'(chan_model(y, u, v, 0)), 8'(chan_model(y, u, v, 1)),
                8'(chan_model(y, u, v, 2))};
    endfunction

    task automatic write_coef(input int idx, input int val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_data = 16'(val);
        @(negedge clk);
        cfg_we = 1'b0;
        if (idx < 12) cf[idx] = val;
    endtask

    task automatic set_rows(input int r0, r1, r2, g0, g1, g2, b0, b1, b2, ro, go, bo);
        write_coef(0, r0); write_coef(1, r1); write_coef(2, r2);
        write_coef(3, g0); write_coef(4, g1); write_coef(5, g2);
        write_coef(6, b0); write_coef(7, b1); write_coef(8, b2);
        write_coef(9, ro); write_coef(10, go); write_coef(11, bo);
    endtask

    task automatic send_word(input logic [31:0] w);
        @(negedge clk);
        in_valid = 1'b1; in_word = w;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic take_pix(input string req, input logic [31:0] exp, input int ppl);
        logic exp_eol;
        pix_ready = 1'b1;
        while (!pix_valid) @(negedge clk);
        exp_eol = (line_pos + 1 >= ppl);
        check(req, pix_data, exp);
        check({req, " eol"}, 32'(pix_eol), 32'(exp_eol));
        line_pos = exp_eol ? 0 : line_pos + 1;
        @(negedge clk);
        pix_ready = 1'b0;
    endtask

    task automatic yuv_word(input string req, input logic [31:0] w, input logic [1:0] code);
        seq_code = code; yuv_mode = 1'b1;
        send_word(w);
        take_pix(req, pix_model(w, code, 1'b0), int'(line_bits) / 16);
        take_pix(req, pix_model(w, code, 1'b1), int'(line_bits) / 16);
    endtask

    task automatic test_reset();
        @(negedge clk);
        check("R1 valid", 32'(pix_valid), 32'd0);
        check("R1 eol", 32'(pix_eol), 32'd0);
        check("R1 ready", 32'(in_ready), 32'd1);
    endtask

    task automatic test_lanes();
        set_rows(1024, 0, 0, 0, 1024, 0, 0, 0, 1024, 0, 0, 0);
        for (int c = 0; c < 4; c++) begin
            yuv_word("R2 R6 lanes", 32'h44332211, 2'(c));
            yuv_word("R2 R6 lanes", 32'hA0B0C0D0, 2'(c));
        end
    endtask

    task automatic test_math();
        set_rows(512, -256, 0, 300, 700, -100, 1024, 0, 1024, 10, -5, -128);
        yuv_word("R3 convert", 32'h50287AC8, 2'd3);
        yuv_word("R3 convert", 32'h11E3337F, 2'd1);
        set_rows(2048, 0, 0, 0, -1024, 0, 0, 0, 1024, 0, 0, -300);
        yuv_word("R4 clamp", 32'h32FFC8FF, 2'd3);
        yuv_word("R4 clamp", 32'h10802040, 2'd0);
    endtask

    task automatic test_bypass();
        yuv_mode = 1'b0;
        send_word(32'hDEADBEEF);
        take_pix("R5 bypass", 32'hDEADBEEF, int'(line_bits) / 32);
        @(negedge clk);
        check("R5 single pixel", 32'(pix_valid), 32'd0);
        send_word(32'h01234567);
        take_pix("R5 bypass", 32'h01234567, int'(line_bits) / 32);
        yuv_mode = 1'b1;
    endtask

    task automatic test_stall();
        logic [31:0] held;
        set_rows(1024, 0, 0, 0, 1024, 0, 0, 0, 1024, 0, 0, 0);
        yuv_word("R8 pre", 32'h11223344, 2'd3);
        seq_code = 2'd3;
        send_word(32'h55667788);
        take_pix("R8 pre", pix_model(32'h55667788, 2'd3, 1'b0), 4);
        // last pixel of the line held under back-pressure
        in_valid = 1'b1; in_word = 32'hCAFEF00D;
        held = pix_data;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R8 held valid", 32'(pix_valid), 32'd1);
            check("R8 held data", pix_data, held);
            check("R7 R8 held eol", 32'(pix_eol), 32'd1);
            check("R8 refuse", 32'(in_ready), 32'd0);
        end
        in_valid = 1'b0;
        take_pix("R8 release", pix_model(32'h55667788, 2'd3, 1'b1), 4);
    endtask

    task automatic test_line_len();
        line_bits = 16'd96;
        yuv_word("R7 line6", 32'h01020304, 2'd2);
        yuv_word("R7 line6", 32'h05060708, 2'd2);
        yuv_word("R7 line6", 32'h090A0B0C, 2'd2);
        line_bits = 16'd64;
    endtask

    task automatic test_ignore();
        write_coef(13, 16'h7FFF);
        write_coef(12, -500);
        yuv_word("R9 ignored idx", 32'h40302010, 2'd3);
        write_coef(9, 7);
        yuv_word("R9 offset write", 32'h40302010, 2'd3);
    endtask

    task automatic test_capture();
        seq_code = 2'd2; yuv_mode = 1'b1;
        send_word(32'h9C8B7A69);
        seq_code = 2'd0; yuv_mode = 1'b0;
        take_pix("R10 capture", pix_model(32'h9C8B7A69, 2'd2, 1'b0), 4);
        take_pix("R10 capture", pix_model(32'h9C8B7A69, 2'd2, 1'b1), 4);
        seq_code = 2'd2; yuv_mode = 1'b1;
        yuv_word("R10 tail", 32'h00FF00FF, 2'd2);
    endtask

    initial begin
        for (int i = 0; i < 12; i++) cf[i] = 0;
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        test_reset();
        test_lanes();
        test_math();
        test_bypass();
        test_stall();
        test_line_len();
        test_ignore();
        test_capture();
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule